// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a target on a two-wire serial bus (SMBus/I2C style) that serves a 256-byte, byte-addressed memory. It samples the bus clock and data lines with the system clock. It answers at a 7-bit bus address formed from a base value plus a small device index, so that up to eight copies can share one bus. One internal 8-bit byte pointer is used for both reads and writes.

In a write transaction, the first data byte after the address loads the pointer. Every later byte in the same transaction is stored at the pointer, and the pointer then advances. In a read transaction, each byte sent returns the location at the pointer, and the pointer then advances. The pointer wraps from 255 to 0 in both directions. A repeated START is accepted, so a master can load the pointer and read from it in one transaction.

On synchronous reset, the whole array is reloaded from a parallel initial-image input and the pointer returns to zero. Bytes written since the last reset are discarded. A sticky flag reports whether the memory has been touched since reset. The target pulls the data line low through an open-drain style enable output.

Top module: `eep_smbus_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, every byte k is reloaded from `init_img[8k+7:8k]` and the pointer is cleared to 0. After such an edge, `sda_oe` is 0 and `accessed` is 0.
- R2: The target ACKs (drives SDA low in the ninth bit) an address byte whose upper seven bits equal 0x50 plus `dev_index`. Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R3: For an address byte that does not match, the target leaves SDA released for the rest of that transaction, and the pointer and memory keep their values.
- R4: In a write transaction, the first data byte is ACKed and loads the pointer.
- R5: In a write transaction, each data byte after the first is ACKed and stored at the pointer, and the pointer then advances. Location 255 is followed by location 0.
- R6: In a read transaction, each byte is sent MSB first and holds the memory byte at the pointer. The pointer then advances, and 255 wraps to 0.
- R7: After a master ACK, the next sequential byte is sent. After a master NACK followed by STOP, the pointer does not change again.
- R8: A repeated START after the pointer-loading byte begins a read that starts at the newly loaded pointer.
- R9: `accessed` goes to 1 on the first matched read or write byte and stays at 1 until reset.
- R10: Reset discards all written data, so the initial image is returned again after reset.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset; reloads the image |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_index | input | IDX_W (3) | Offset added to the base address 0x50 |
| init_img | input | DEPTH*8 (2048) | Initial image; byte k is in bits 8k+7:8k |
| accessed | output | 1 | Sticky flag showing a matched access since reset |

## Verification
On a read, the byte at the pointer is captured in the same cycle that the pointer advance is issued. The byte sent must therefore be the value from before the increment. The bench provokes this at the 255-to-0 boundary with back-to-back ACKed reads, after loading the pointer through a repeated START. A scoreboard compares each received byte against a model memory that advances its own pointer, so a fetch taken one place early or late shows up as a mismatch. Reset is then applied after writes, and the image bytes are read back to confirm that the reload overrides the written data.

// File: rtl/eep_pkg.sv
// Package: shared protocol state for the serial byte-memory target.
// Assumes: one bus transaction is tracked at a time.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
// eep_line_sync: brings one asynchronous bus line into the clock domain
// and keeps the previous synchronized value for edge detection.
// Assumes: STAGES >= 2; the line idles high (pulled up).
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            line_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], line_i};
            line_q <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
endmodule

// File: rtl/eep_bus_fsm.sv
// eep_bus_fsm: bit and byte engine of the bus target. It detects START and
// STOP, shifts address and data bytes in, drives ACK and read data, and
// reports byte-level events to the storage.
// Assumes: synchronized lines; SCL is slow relative to clk (several clocks per phase).
module eep_bus_fsm
    import eep_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          scl_q,
    input  logic          sda_s,
    input  logic          sda_q,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic          wr_first,
    output logic [DW-1:0] wr_data,
    output logic          rd_adv
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    eep_state_e    state;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bitcnt;
    logic          is_read;
    logic          first;
    logic          go_on;

    logic scl_rise, scl_fall, start_ev, stop_ev;

    // Decode bus edges and the START/STOP conditions.
    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

    // Protocol sequencer: one state per byte phase and ACK slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            sda_oe   <= 1'b0;
            is_read  <= 1'b0;
            first    <= 1'b0;
            go_on    <= 1'b0;
            wr_stb   <= 1'b0;
            wr_first <= 1'b0;
            wr_data  <= '0;
            rd_adv   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_adv <= 1'b0;
            if (start_ev) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            if (shreg[DW-1:1] == my_addr) begin
                                state   <= ST_ADDR_ACK;
                                sda_oe  <= 1'b1;
                                is_read <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                state  <= ST_RD;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                rd_adv <= 1'b1;
                            end else begin
                                state  <= ST_WR;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            state    <= ST_WR_ACK;
                            sda_oe   <= 1'b1;
                            wr_stb   <= 1'b1;
                            wr_first <= first;
                            wr_data  <= shreg;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_WR;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            first  <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST) begin
                                state  <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[DW-2:0], 1'b0};
                                sda_oe <= ~shreg[DW-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            go_on <= ~sda_s;
                        end else if (scl_fall) begin
                            if (go_on) begin
                                state  <= ST_RD;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                rd_adv <= 1'b1;
                                bitcnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_store.sv
// eep_store: byte array, shared byte pointer and sticky access flag.
// Assumes: DEPTH is a power of two so the pointer wraps naturally; DW >= pointer width.
module eep_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEPTH*DW-1:0] init_img,
    input  logic                wr_stb,
    input  logic                wr_first,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_adv,
    output logic [DW-1:0]       rd_data,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output logic                accessed
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    // Reload the image on reset; otherwise store non-pointer write bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= init_img[i*DW +: DW];
            end
        end else if (wr_stb && !wr_first) begin
            mem[ptr] <= wr_data;
        end
    end

    // Pointer: loaded by the first write byte, stepped by data bytes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_stb && wr_first) begin
            ptr <= wr_data[PW-1:0];
        end else if (wr_stb || rd_adv) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Sticky flag raised by any matched byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accessed <= 1'b0;
        end else if (wr_stb || rd_adv) begin
            accessed <= 1'b1;
        end
    end

    assign rd_data = mem[ptr];
endmodule

// File: rtl/eep_smbus_target.sv
// eep_smbus_target: top of the serial byte-memory target. It synchronizes
// both bus lines, runs the protocol engine and holds the storage.
// Assumes: the caller combines sda_oe into an open-drain pad; BASE_ADDR+MAX_DEV-1 fits in 7 bits.
module eep_smbus_target #(
    parameter int          DEPTH     = 256,
    parameter int          MAX_DEV   = 8,
    parameter int          SYNC      = 2,
    parameter logic [6:0]  BASE_ADDR = 7'h50,
    parameter int          IDX_W     = $clog2(MAX_DEV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [IDX_W-1:0]   dev_index,
    input  logic [DEPTH*8-1:0] init_img,
    output logic               accessed
);
    localparam int DW = 8;
    localparam int AW = 7;
    localparam int PW = $clog2(DEPTH);

    logic [1:0]    raw_lines;
    logic [1:0]    lines_s;
    logic [1:0]    lines_q;
    logic          scl_s;
    logic [AW-1:0] my_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] wr_data;
    logic          wr_stb, wr_first, rd_adv;
    logic [PW-1:0] ptr;

    assign raw_lines = {sda_i, scl_i};
    assign scl_s     = lines_s[0];
    assign my_addr   = BASE_ADDR + {{(AW-IDX_W){1'b0}}, dev_index};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        eep_line_sync #(.STAGES(SYNC)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_s (lines_s[g]),
            .line_q (lines_q[g])
        );
    end

    eep_bus_fsm #(.DW(DW), .AW(AW)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[0]),
        .scl_q    (lines_q[0]),
        .sda_s    (lines_s[1]),
        .sda_q    (lines_q[1]),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_first (wr_first),
        .wr_data  (wr_data),
        .rd_adv   (rd_adv)
    );

    eep_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_img (init_img),
        .wr_stb   (wr_stb),
        .wr_first (wr_first),
        .wr_data  (wr_data),
        .rd_adv   (rd_adv),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .accessed (accessed)
    );
endmodule

// File: rtl/eep_smbus_target_chk.sv
// eep_smbus_target_chk: temporal checks on pointer movement, the sticky flag
// and SDA drive timing. Bound into every eep_smbus_target instance.
// Assumes: reset is asserted from time zero.
module eep_smbus_target_chk #(
    parameter int PW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          accessed,
    input logic          wr_stb,
    input logic          wr_first,
    input logic [DW-1:0] wr_data,
    input logic          rd_adv,
    input logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] ONE = PW'(1);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr == '0 && !sda_oe && !accessed));

    assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_first) |=> (ptr == $past(wr_data[PW-1:0])));

    assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_first) |=> (ptr == $past(ptr) + ONE));

    assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> (ptr == $past(ptr) + ONE));

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !rd_adv) |=> $stable(ptr));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accessed |=> accessed);

    assert_sda_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind eep_smbus_target eep_smbus_target_chk #(.PW(PW), .DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .accessed (accessed),
    .wr_stb   (wr_stb),
    .wr_first (wr_first),
    .wr_data  (wr_data),
    .rd_adv   (rd_adv),
    .ptr      (ptr)
);

// File: tb/test_eep_smbus_target.sv
`timescale 1ns/1ps
module test_eep_smbus_target;
    localparam int DEPTH = 256;
    localparam int HP    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               m_scl = 1'b1;
    logic               m_low = 1'b0;
    logic               sda_oe;
    logic               sda_bus;
    logic [2:0]         dev_idx = 3'd3;
    logic [DEPTH*8-1:0] img;
    logic               accessed;

    int total = 0;
    int bad   = 0;
    int r11_viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] model_mem [DEPTH];
    logic [7:0] model_ptr;
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    eep_smbus_target i_eep_smbus_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .dev_index (dev_idx),
        .init_img  (img),
        .accessed  (accessed)
    );

    function automatic logic [7:0] img_byte(int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Scoreboard monitor: pairs each received byte with its expected value.
    always @(negedge clk) begin
        if (got_q.size() != 0 && exp_q.size() != 0) begin
            chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    // SDA drive timing monitor (R11).
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && m_scl) r11_viol++;
        prev_oe = sda_oe;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        for (int i = 0; i < DEPTH; i++) model_mem[i] = img_byte(i);
        model_ptr = 8'h00;
    endtask

    task automatic bus_bit(input logic drive_low, output logic seen);
        m_low = drive_low;
        tick(HP);
        m_scl = 1'b1;
        tick(HP / 2);
        seen = sda_bus;
        tick(HP / 2);
        m_scl = 1'b0;
        tick(3);
    endtask

    task automatic bus_start();
        m_low = 1'b0;
        tick(HP);
        m_scl = 1'b1;
        tick(HP);
        m_low = 1'b1;
        tick(HP);
        m_scl = 1'b0;
        tick(3);
    endtask

    task automatic bus_stop();
        m_low = 1'b1;
        tick(HP);
        m_scl = 1'b1;
        tick(HP);
        m_low = 1'b0;
        tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(!b[i], s);
        bus_bit(1'b0, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b0, s);
            v = {v[6:0], s};
        end
        bus_bit(master_ack, s);
    endtask

    // Driver: address + pointer byte + n data bytes, no STOP.
    task automatic wr_part(logic [6:0] a, logic [7:0] p, int n, logic [7:0] d0, string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk({req, " addr ack"}, 8'(ack), 8'd1);
        send_byte(p, ack);
        chk("R4 ptr byte ack", 8'(ack), 8'd1);
        model_ptr = p;
        for (int k = 0; k < n; k++) begin
            send_byte(8'(d0 + 8'(k * 17)), ack);
            chk("R5 data ack", 8'(ack), 8'd1);
            model_mem[model_ptr] = 8'(d0 + 8'(k * 17));
            model_ptr = model_ptr + 8'd1;
        end
    endtask

    // Driver: START + read address + n bytes, last one NACKed, no STOP.
    task automatic rd_part(logic [6:0] a, int n, string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({a, 1'b1}, ack);
        chk({req, " read addr ack"}, 8'(ack), 8'd1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model_mem[model_ptr]);
            tag_q.push_back({req, " read data"});
            model_ptr = model_ptr + 8'd1;
            recv_byte(k < n - 1, v);
            got_q.push_back(v);
        end
    endtask

    initial begin
        logic ack;
        for (int i = 0; i < DEPTH; i++) img[i*8 +: 8] = img_byte(i);
        tick(4);
        do_reset();
        // R1: state after reset
        chk("R1 sda released", 8'(sda_oe), 8'd0);
        chk("R1 flag clear", 8'(accessed), 8'd0);

        // R6/R7: sequential read from 0, then NACK+STOP, then continue at 2
        rd_part(7'h53, 2, "R6");
        bus_stop();
        rd_part(7'h53, 1, "R7");
        bus_stop();
        chk("R9 flag set", 8'(accessed), 8'd1);

        // R3: wrong address ignored
        bus_start();
        send_byte({7'h52, 1'b0}, ack);
        chk("R3 no addr ack", 8'(ack), 8'd0);
        send_byte(8'h10, ack);
        chk("R3 no data ack", 8'(ack), 8'd0);
        bus_stop();
        rd_part(7'h53, 1, "R3");
        bus_stop();

        // R4/R5: write across the top of the array
        wr_part(7'h53, 8'hFE, 3, 8'hA1, "R5");
        bus_stop();
        rd_part(7'h53, 1, "R5");
        bus_stop();

        // R8/R6: load pointer, repeated START, read across the wrap
        wr_part(7'h53, 8'hFE, 0, 8'h00, "R8");
        rd_part(7'h53, 4, "R8");
        bus_stop();

        // R2: move to index 0, base address alone
        dev_idx = 3'd0;
        bus_start();
        send_byte({7'h53, 1'b1}, ack);
        chk("R2 old addr ignored", 8'(ack), 8'd0);
        bus_stop();
        wr_part(7'h50, 8'h40, 1, 8'h3C, "R2");
        bus_stop();
        wr_part(7'h50, 8'h40, 0, 8'h00, "R2");
        rd_part(7'h50, 1, "R2");
        bus_stop();

        // R10/R1/R9: reset discards writes and clears the flag
        tick(20);
        do_reset();
        chk("R9 flag cleared by reset", 8'(accessed), 8'd0);
        wr_part(7'h50, 8'hFE, 0, 8'h00, "R10");
        rd_part(7'h50, 3, "R10");
        bus_stop();

        tick(20);
        chk("R11 drive changes in low phase", 8'(r11_viol), 8'd0);
        chk("scoreboard drained", 8'(exp_q.size()), 8'(got_q.size()));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(150000);
        total++;
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule